// File: doc/BRIEF.md
# Latency-Insensitive Join Wrapper

This block is the control wrapper around a synchronous compute kernel that reads several input channels and writes several output channels. Each input channel gets a one-word landing register. The kernel is enabled in a cycle only when two conditions hold. First, every input channel has a word, either parked in its register or arriving now. Second, no output channel is asking to stop. When the kernel fires, all output channels present a valid word in the same cycle. Every parked word is then consumed.

Back-pressure toward the inputs comes only from the landing registers. A channel is told to stop only while its register holds a word that arrived in an earlier cycle. A channel whose word is arriving in the current cycle never gets a stop. The stop outputs therefore depend only on registered state. This keeps them free of a combinational path back to the upstream pipeline stage, whose stop response is itself combinational.

The kernel sits outside this block. It receives the selected input words on `krn_in` and returns its results on `krn_out`. It advances only in cycles where `krn_en` is high.

Top module: `lid_join_shell`

## Requirements
- R1: When any bit of `dn_stop` is high, `krn_en` is low and every bit of `dn_val` is low.
- R2: `krn_en` is high exactly when reset is released, every input channel has a word (parked, or `up_val` high and accepted this cycle), and no `dn_stop` bit is high.
- R3: In a firing cycle every bit of `dn_val` is high together. Output lane j of `dn_data` (bits `[j*W +: W]`) equals lane j of `krn_out`.
- R4: While the kernel does not fire, a parked word stays parked and unchanged. A channel with an empty register that sees `up_val` high loads that word in the same cycle, even while other channels are still missing.
- R5: `up_stop[i]` is high exactly when channel i's register holds a word that arrived in an earlier cycle and is not yet consumed. A word offered on a channel while its `up_stop` is high is not accepted and never reaches the kernel.
- R6: A firing cycle empties every register at the next clock edge. In the firing cycle itself, `up_stop` stays high for channels whose word was parked earlier.
- R7: On each output channel, `dn_val[j]` is never high in a cycle where `dn_stop[j]` is high.
- R8: During reset and after it, all registers are empty. `dn_val`, `up_stop` and `krn_en` are low until new words arrive.
- R9: Lane i of `krn_in` (bits `[i*W +: W]`) carries the parked word of channel i when one is parked. Otherwise it carries lane i of `up_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_val | input | N_IN | Per input channel: a word is offered |
| up_data | input | N_IN*W | Input words, lane i at bits [i*W +: W] |
| up_stop | output | N_IN | Per input channel: hold the offered word, register occupied |
| dn_val | output | N_OUT | Per output channel: a result word is valid |
| dn_data | output | N_OUT*W | Result words, lane j at bits [j*W +: W] |
| dn_stop | input | N_OUT | Per output channel: downstream cannot accept |
| krn_en | output | 1 | Kernel advance enable (fire) |
| krn_in | output | N_IN*W | Selected input words to the kernel |
| krn_out | input | N_OUT*W | Kernel results |

## Verification
Suppose a landing register wrongly stays full or wrongly empties. The fault shows in the same cycle as a wrong `up_stop` bit. It shows again in the next firing cycle as a result computed from the wrong word. A lost or duplicated word shifts every later result in the output stream, so the error keeps showing from that point on. A bad firing condition shows at once as `krn_en` and `dn_val` disagreeing with the channel occupancy and the downstream stops the bench tracks.

// File: rtl/lid_join_shell.sv
module lid_join_shell #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    up_val,
  input  logic [N_IN*W-1:0]  up_data,
  output logic [N_IN-1:0]    up_stop,
  output logic [N_OUT-1:0]   dn_val,
  output logic [N_OUT*W-1:0] dn_data,
  input  logic [N_OUT-1:0]   dn_stop,
  output logic               krn_en,
  output logic [N_IN*W-1:0]  krn_in,
  input  logic [N_OUT*W-1:0] krn_out
);

  logic [N_IN-1:0]   parked;
  logic [N_IN*W-1:0] park_word;
  logic [N_IN-1:0]   have;
  logic              any_stop;
  logic              fire;

  assign any_stop = |dn_stop;
  assign have     = parked | up_val;
  assign fire     = rst_n & (&have) & ~any_stop;

  assign krn_en  = fire;
  assign dn_val  = {N_OUT{fire}};
  assign dn_data = krn_out;
  assign up_stop = parked;

  always_ff @(posedge clk) begin
    if (!rst_n)    parked <= '0;
    else if (fire) parked <= '0;
    else           parked <= parked | up_val;
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!parked[i] && up_val[i] && !fire)
        park_word[i*W +: W] <= up_data[i*W +: W];
    end

    assign krn_in[i*W +: W] = parked[i] ? park_word[i*W +: W] : up_data[i*W +: W];

    // R4
    keep_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (parked[i] && !fire) |=> (parked[i] && $stable(park_word[i*W +: W])));

    // R4
    late_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!parked[i] && up_val[i] && !fire) |=> parked[i]);

    // R6
    consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !up_stop[i]);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    // R7
    no_val_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_stop[j] |-> !dn_val[j]);
  end

  // R1
  stop_blocks_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_stop) |-> !krn_en);

  // R2
  fire_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    krn_en |-> (&(up_stop | up_val)));

  // R3
  all_out_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dn_val) == 0) || (&dn_val));

  // R8
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> (up_stop == '0));

endmodule

// File: tb/lid_join_shell_test.sv
module lid_join_shell_test;
  localparam int N_IN  = 3;
  localparam int N_OUT = 2;
  localparam int W     = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [N_IN-1:0]    up_val = '0;
  logic [N_IN*W-1:0]  up_data = '0;
  logic [N_IN-1:0]    up_stop;
  logic [N_OUT-1:0]   dn_val;
  logic [N_OUT*W-1:0] dn_data;
  logic [N_OUT-1:0]   dn_stop = '0;
  logic               krn_en;
  logic [N_IN*W-1:0]  krn_in;
  logic [N_OUT*W-1:0] krn_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] src_word [N_IN];
  logic [W-1:0] q [N_IN][$];

  always #2 clk = ~clk;

  lid_join_shell #(.N_IN(N_IN), .N_OUT(N_OUT), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .up_val(up_val), .up_data(up_data), .up_stop(up_stop),
    .dn_val(dn_val), .dn_data(dn_data), .dn_stop(dn_stop), .krn_en(krn_en),
    .krn_in(krn_in), .krn_out(krn_out));

  function automatic logic [W-1:0] kernel(input logic [N_IN*W-1:0] v, input int lane);
    logic [W-1:0] s = W'(lane);
    for (int i = 0; i < N_IN; i++) s = s + v[i*W +: W];
    return s;
  endfunction

  always_comb
    for (int j = 0; j < N_OUT; j++) krn_out[j*W +: W] = kernel(krn_in, j);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N_IN-1:0] v, input logic [N_OUT-1:0] s);
    logic [N_IN-1:0] exp_stop, xfer, avail;
    logic [N_IN*W-1:0] words;
    bit fire;
    @(posedge clk);
    #1;
    for (int i = 0; i < N_IN; i++) begin
      exp_stop[i] = (q[i].size() > 0);
      up_val[i] = v[i];
      up_data[i*W +: W] = (v[i] && !exp_stop[i]) ? src_word[i] : W'($urandom);
    end
    dn_stop = s;
    #2;
    for (int i = 0; i < N_IN; i++) begin
      xfer[i]  = up_val[i] && !exp_stop[i];
      avail[i] = exp_stop[i] || up_val[i];
      words[i*W +: W] = exp_stop[i] ? q[i][0] : up_data[i*W +: W];
    end
    fire = (&avail) && !(|dn_stop);
    // R5 and R6: stop only toward parked channels, also in firing cycles
    chk(up_stop == exp_stop, "R5/R6 up_stop", up_stop, exp_stop);
    // R2
    chk(krn_en == fire, "R2 krn_en", krn_en, fire);
    // R1
    if (|dn_stop) chk(!krn_en && dn_val == '0, "R1 stop blocks", {krn_en, dn_val}, 0);
    // R7
    chk((dn_val & dn_stop) == '0, "R7 val under stop", dn_val & dn_stop, 0);
    // R3
    chk(dn_val == {N_OUT{fire}}, "R3 dn_val", dn_val, {N_OUT{fire}});
    if (fire) begin
      for (int j = 0; j < N_OUT; j++)
        // R9 and R4: parked word or arriving word reaches the kernel
        chk(dn_data[j*W +: W] == kernel(words, j), "R9/R4 dn_data",
            dn_data[j*W +: W], kernel(words, j));
    end
    for (int i = 0; i < N_IN; i++) begin
      if (xfer[i]) begin
        q[i].push_back(up_data[i*W +: W]);
        src_word[i] = src_word[i] + W'(i + 1);
      end
      if (fire) void'(q[i].pop_front());
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N_IN; i++) src_word[i] = W'(16 * i + 1);
    up_val = '1;
    repeat (3) @(posedge clk);
    #3;
    // R8
    chk(!krn_en && dn_val == '0 && up_stop == '0, "R8 reset outputs",
        {krn_en, dn_val, up_stop}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    up_val = '0;
    // R8: empty after reset
    #2;
    chk(up_stop == '0 && !krn_en, "R8 empty after reset", {up_stop, krn_en}, 0);

    // R2: everything arrives together
    step('1, '0);
    // R4: staggered arrival
    step(3'b001, '0);
    step(3'b011, '0);
    step(3'b100, '0);
    // R1: all present but stopped downstream
    step(3'b111, 2'b01);
    step(3'b000, 2'b10);
    // R6: release, fire from parked words
    step(3'b000, '0);
    step(3'b000, '0);
    // R5: offers under stop are ignored
    step(3'b010, '0);
    step(3'b111, 2'b11);
    step(3'b101, '0);

    for (int n = 0; n < 6000; n++) begin
      logic [N_IN-1:0] v;
      logic [N_OUT-1:0] s;
      int pv = (n / 1000) % 3 == 0 ? 90 : ((n / 1000) % 3 == 1 ? 50 : 20);
      int ps = (n / 1500) % 2 == 0 ? 15 : 50;
      for (int i = 0; i < N_IN; i++) v[i] = ($urandom % 100) < pv;
      for (int j = 0; j < N_OUT; j++) s[j] = ($urandom % 100) < ps;
      step(v, s);
    end
    for (int i = 0; i < N_IN; i++)
      // R5: never more than one word parked per channel
      chk(q[i].size() <= 1, "R5 occupancy", q[i].size(), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule